// File: doc/BRIEF.md
# Parallel-Lane Pseudo-Random Sequence Checker

This block checks a pseudo-random bit sequence that arrives as a word of `LANES` bits on every cycle of a divided clock. The feedback polynomial is not fixed: it is supplied at run time as a tap mask. From the bits it has already received, the checker predicts each new bit and compares the prediction with the bit that actually arrived. It then adds the mismatches to a 64-bit error counter and the number of checked bits to a 64-bit bit counter.

A two-bit mode input sets what the block does. In the clearing mode it learns the stream by loading its history with received bits and zeroes both counters. In the measuring mode it counts errors and checked bits. In the holding modes the counters keep their values, so software or a scan path can read them at leisure. Because each prediction uses received bits rather than earlier predictions, one corrupted bit shows up once in its own position and once at every tap that later reads it.

Top module: `prbs_lane_checker`

## Requirements
- R1: `mode` is decoded as 2'b00 = clear, 2'b01 = measure, 2'b10 = hold, and 2'b11 = hold.
- R2: Bit 0 of `rx_word` is the earliest bit of the word. Each bit is predicted as the XOR of the received bits selected by `tap_mask`, where mask bit i selects the bit received i+1 positions earlier. That earlier bit may sit in the same word or in a previous one.
- R3: A cycle in the clearing mode sets both counters to zero at the next clock edge and feeds the received bits into the prediction history.
- R4: Each measuring cycle raises `bit_count` by exactly `LANES`.
- R5: In either hold code, both counters keep their values for as long as the code is applied, whatever arrives on `rx_word`.
- R6: Each measuring cycle raises `err_count` by the number of lanes whose received bit differs from its prediction.
- R7: After at least ceil(`POLY_W`/`LANES`) clearing cycles on a correct stream with the matching mask, measuring that stream adds no errors. Example mask for a 7-bit register with taps 7 and 6: 7'b1100000.
- R8: When the mask does not match the stream's polynomial, a measuring run gives a nonzero error count.
- R9: A single inverted bit in an otherwise correct stream adds exactly (number of taps + 1) errors, provided every later bit that reads it falls inside the measured window.
- R10: Both counters saturate at 2^`CNT_W`-1 and do not wrap.
- R11: The asynchronous active-high `rst` clears both counters and the history.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Divided word clock |
| rst | input | 1 | Asynchronous active-high reset |
| mode | input | 2 | Operating mode: clear, measure, hold |
| tap_mask | input | POLY_W | Feedback taps; bit i selects the bit received i+1 positions back |
| rx_word | input | LANES | Received bits; bit 0 is earliest |
| err_count | output | CNT_W | Saturating count of mispredicted bits |
| bit_count | output | CNT_W | Saturating count of checked bits |

## Verification
A wrong prediction history cannot hide. One bad history bit produces errors within the first measured word and keeps producing them until every tap has moved past it, so the error count on a clean stream leaves zero on the first edge of the run. The single-bit injection pins down the exact error multiplicity, and in particular which lane counts as earliest. Counter faults show at the edge after every cycle: a wrong step in the bit count, movement during hold, or a wrap near full scale.

// File: rtl/prbs_lane_checker.sv
module prbs_lane_checker #(
  parameter int LANES  = 16,
  parameter int POLY_W = 7,
  parameter int CNT_W  = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        mode,
  input  logic [POLY_W-1:0] tap_mask,
  input  logic [LANES-1:0]  rx_word,
  output logic [CNT_W-1:0]  err_count,
  output logic [CNT_W-1:0]  bit_count
);

  localparam int PC_W = $clog2(LANES + 1);
  localparam logic [CNT_W-1:0] CNT_MAX  = '1;
  localparam logic [CNT_W-1:0] LANE_INC = CNT_W'(LANES);

  logic [POLY_W-1:0] hist, hist_nxt;
  logic [LANES-1:0]  miss;
  logic [PC_W-1:0]   miss_cnt;

  always_comb begin
    logic [POLY_W-1:0] h;
    h = hist;
    for (int j = 0; j < LANES; j++) begin
      miss[j] = rx_word[j] ^ (^(h & tap_mask));
      h = {h[POLY_W-2:0], rx_word[j]};
    end
    hist_nxt = h;
  end

  always_comb begin
    miss_cnt = '0;
    for (int j = 0; j < LANES; j++) miss_cnt = miss_cnt + PC_W'(miss[j]);
  end

  function automatic logic [CNT_W-1:0] sat_add(input logic [CNT_W-1:0] a,
                                               input logic [CNT_W-1:0] b);
    logic [CNT_W:0] s;
    s = {1'b0, a} + {1'b0, b};
    return s[CNT_W] ? CNT_MAX : s[CNT_W-1:0];
  endfunction

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      hist      <= '0;
      err_count <= '0;
      bit_count <= '0;
    end else begin
      hist <= hist_nxt;
      case (mode)
        2'b00: begin
          err_count <= '0;
          bit_count <= '0;
        end
        2'b01: begin
          err_count <= sat_add(err_count, CNT_W'(miss_cnt));
          bit_count <= sat_add(bit_count, LANE_INC);
        end
        default: ;
      endcase
    end
  end

  p_clear_r3: assert property (@(posedge clk) disable iff (rst)
    mode == 2'b00 |=> (err_count == '0) && (bit_count == '0));

  p_hold_r5: assert property (@(posedge clk) disable iff (rst)
    mode[1] |=> $stable(err_count) && $stable(bit_count));

  p_bit_step_r4: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'b01) && (bit_count <= CNT_MAX - LANE_INC)
    |=> bit_count == $past(bit_count) + LANE_INC);

  p_err_step_r6: assert property (@(posedge clk) disable iff (rst)
    mode == 2'b01 |=> (err_count >= $past(err_count)) &&
                      (err_count - $past(err_count) <= LANE_INC));

  p_no_wrap_r10: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'b01) && (bit_count == CNT_MAX) |=> bit_count == CNT_MAX);

endmodule

// File: tb/test_prbs_lane_checker.sv
module test_prbs_lane_checker;
  localparam int LANES = 16;
  localparam int PW    = 7;
  localparam logic [PW-1:0] GOOD_MASK = 7'b1100000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [1:0] mode = 2'b10;
  logic [PW-1:0] mask = GOOD_MASK;
  logic [LANES-1:0] rx = '0;
  logic [63:0] err_count, bit_count;

  logic [1:0] s_mode = 2'b10;
  logic [LANES-1:0] s_rx = '0;
  logic [7:0] s_err, s_bits;

  always #10 clk = ~clk;

  prbs_lane_checker #(.LANES(LANES), .POLY_W(PW), .CNT_W(64)) i_prbs_lane_checker (
    .clk(clk), .rst(rst), .mode(mode), .tap_mask(mask), .rx_word(rx),
    .err_count(err_count), .bit_count(bit_count));

  prbs_lane_checker #(.LANES(LANES), .POLY_W(PW), .CNT_W(8)) i_prbs_lane_checker_sat (
    .clk(clk), .rst(rst), .mode(s_mode), .tap_mask(GOOD_MASK), .rx_word(s_rx),
    .err_count(s_err), .bit_count(s_bits));

  typedef struct packed {
    logic        chk_err;
    logic [63:0] e;
    logic [63:0] b;
    logic [7:0]  req;
  } item_t;

  item_t sb[$];
  int tests = 0, fails = 0;
  logic [63:0] exp_err = '0, exp_bits = '0;
  logic [PW-1:0] gen_hist = 7'h5A;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] expv);
    tests++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  task automatic next_word(output logic [LANES-1:0] w);
    for (int j = 0; j < LANES; j++) begin
      w[j] = ^(gen_hist & GOOD_MASK);
      gen_hist = {gen_hist[PW-2:0], w[j]};
    end
  endtask

  task automatic step(input logic [1:0] m, input logic [LANES-1:0] w,
                      input int err_add, input logic chk, input logic [7:0] req);
    item_t it;
    @(negedge clk);
    mode = m;
    rx = w;
    case (m)
      2'b00: begin exp_err = '0; exp_bits = '0; end
      2'b01: begin exp_err += 64'(err_add); exp_bits += 64'(LANES); end
      default: ;
    endcase
    it.chk_err = chk; it.e = exp_err; it.b = exp_bits; it.req = req;
    sb.push_back(it);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      #5;
      if (sb.size() > 0) begin
        item_t it;
        it = sb.pop_front();
        check($sformatf("R%0d bit_count", it.req), bit_count, it.b);
        if (it.chk_err) check($sformatf("R%0d err_count", it.req), err_count, it.e);
      end
    end
  end

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    #4_000_000;
    tests++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    logic [LANES-1:0] w;
    #35;
    // R11: reset state on both instances
    check("R11 err", err_count, 0);
    check("R11 bits", bit_count, 0);
    check("R11 small err", 64'(s_err), 0);
    @(negedge clk);
    rst = 1'b0;

    // R3 training on the correct stream, counters stay zero
    for (int k = 0; k < 2 * PW; k++) begin next_word(w); step(2'b00, w, 0, 1'b1, 8'd3); end
    // R7, R4, R2: clean stream measured, no errors
    for (int k = 0; k < 32; k++) begin next_word(w); step(2'b01, w, 0, 1'b1, 8'd7); end
    // R5: hold with code 10 while the stream moves on
    for (int k = 0; k < 8; k++) begin next_word(w); step(2'b10, w, 0, 1'b1, 8'd5); end
    // R1: code 11 also holds
    for (int k = 0; k < 8; k++) begin next_word(w); step(2'b11, ~w, 0, 1'b1, 8'd1); end
    // resync after the corrupted hold words
    for (int k = 0; k < 2; k++) begin next_word(w); step(2'b00, w, 0, 1'b1, 8'd3); end
    for (int k = 0; k < 4; k++) begin next_word(w); step(2'b01, w, 0, 1'b1, 8'd4); end
    // R9, R6: one flipped bit at lane 3 hits lanes 3, 9, 10 of the same word
    next_word(w); step(2'b01, w ^ 16'h0008, 3, 1'b1, 8'd9);
    for (int k = 0; k < 4; k++) begin next_word(w); step(2'b01, w, 0, 1'b1, 8'd6); end
    // R3: clearing mode zeroes counters
    next_word(w); step(2'b00, w, 0, 1'b1, 8'd3);

    // R8: wrong mask
    @(negedge clk); mask = GOOD_MASK + 7'd1;
    for (int k = 0; k < 2 * PW; k++) begin next_word(w); step(2'b00, w, 0, 1'b1, 8'd3); end
    for (int k = 0; k < 16; k++) begin next_word(w); step(2'b01, w, 0, 1'b0, 8'd4); end
    next_word(w); step(2'b10, w, 0, 1'b0, 8'd5);
    @(negedge clk);
    tests++;
    if (err_count == 0) begin
      fails++;
      $display("FAIL R8: actual %0d expected nonzero", err_count);
    end
    check("R4 wrong-mask bits", bit_count, 256);
    mask = GOOD_MASK;

    // R10 on the narrow instance: all-ones stream mispredicts every lane
    for (int k = 0; k < 2; k++) begin @(negedge clk); s_mode = 2'b00; s_rx = '1; end
    for (int k = 0; k < 15; k++) begin @(negedge clk); s_mode = 2'b01; end
    @(negedge clk); s_mode = 2'b10;
    check("R6 small err", 64'(s_err), 240);
    check("R4 small bits", 64'(s_bits), 240);
    for (int k = 0; k < 5; k++) begin @(negedge clk); s_mode = 2'b01; end
    @(negedge clk); s_mode = 2'b10;
    check("R10 small err", 64'(s_err), 255);
    check("R10 small bits", 64'(s_bits), 255);
    @(negedge clk); s_mode = 2'b00;
    @(negedge clk); s_mode = 2'b10;
    check("R3 small clear", 64'(s_bits), 0);

    repeat (3) @(negedge clk);
    check("scoreboard drained", 64'(sb.size()), 0);
    summary();
  end
endmodule